// File: doc/BRIEF.md
# Channel-Attention Command and Status Controller

This block is the control core of a descriptor-driven Ethernet controller. Software writes a 16-bit control word and raises a channel-attention pulse. The block then decodes the word and updates two small state machines, one for the command unit and one for the receive unit. It keeps four event flags that software acknowledges, and it presents the unit states and the flags together as one 16-bit status word.

When the command unit is active after a decode, the block walks a list of action commands. A feeder, either a fetch engine or a testbench, hands over one 16-bit header per command on a valid/ready handshake, together with a flag that tells whether the next link is null. For each header the block emits a busy status and then a completion status. It honours the header's end-of-list, suspend-after and interrupt-after bits. At the end of processing it pulses an interrupt request if any command asked for one. Attention pulses that arrive while the block is busy are counted. Each counted pulse causes one more decode of the control word.

Top module: `cactl_core`

## Requirements
- R1: After synchronous reset, status_word is 0x0010 (command unit idle, receive unit suspended, no flags), and cmd_ready, cmd_stat_we and irq are 0.
- R2: status_word places the flags in bits 15:12 and the command-unit state in bits 11:8 (idle 0, suspended 1, active 2). It places the receive-unit state in bits 7:4 (idle 0, suspended 1, ready 4). Bits 3:0 are 0. The flags are: bit 15 command done with interrupt, bit 14 frame received, bit 13 command unit left active, bit 12 receive unit left active.
- R3: In a decode, each set bit among ctl_word[15:12] clears the flag at the same position.
- R4: The command-unit opcode is ctl_word[10:8]. Opcode 1 makes the unit active. Opcode 4 makes it suspended and sets bit 13. Any other value leaves the unit unchanged.
- R5: The receive-unit opcode is ctl_word[6:4]. Opcodes 1 and 2 make the unit idle. Opcodes 3 and 4 make it suspended and set bit 12. Other values change nothing.
- R6: ctl_word[7] performs a soft reset after the opcodes are applied: the command unit goes idle, the receive unit goes suspended, all flags clear, and any pending interrupt request is dropped.
- R7: When idle, a decode takes place on the clock edge where ca_pulse is sampled high, or on the edge after a walk ends while counted pulses remain. ctl_word is sampled on that edge, and status_word shows the result after it.
- R8: If the command unit is active after a decode, cmd_ready rises. A header accepted on an edge produces cmd_stat_we with cmd_stat 0x4000 in the next cycle, then cmd_stat_we with cmd_stat 0xA000 in the cycle after.
- R9: When a command completes, bit 15 becomes that header's interrupt-after bit (header bit 13).
- R10: The walk stops after a header whose end-of-list bit (bit 15) is set, or whose cmd_link_null was high. In both cases the command unit stays active. A set suspend-after bit (bit 14) moves the command unit to suspended and stops the walk. A decode that leaves the command unit inactive starts no walk.
- R11: irq pulses for exactly one cycle when processing ends with no counted pulses left, provided a command with interrupt-after completed since the last pulse.
- R12: Each ca_pulse cycle seen while the block is walking adds one to a saturating counter. Each count produces one further decode, and so possibly one further walk.
- R13: rx_frame_evt sets bit 14 in any cycle. In the same cycle it takes precedence over an acknowledge of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ca_pulse | input | 1 | Channel-attention request, one count per high cycle |
| ctl_word | input | 16 | Control word sampled at each decode |
| rx_frame_evt | input | 1 | Frame-received event from the receive path |
| cmd_valid | input | 1 | Header available from the feeder |
| cmd_hdr | input | 16 | List entry header |
| cmd_link_null | input | 1 | The entry's next link is null or zero |
| cmd_ready | output | 1 | Block waits for a header |
| cmd_stat_we | output | 1 | Command status write strobe |
| cmd_stat | output | 16 | Command status value (0x4000 busy, 0xA000 done) |
| status_word | output | 16 | Composed flags and unit states |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A decode shows up in status_word one edge after the attention pulse is sampled. A header accepted on edge N produces the busy strobe after edge N and the completion strobe after edge N+1. The command-done flag and any suspension of the command unit become visible after edge N+1. The interrupt pulse follows the edge that closes the last walk. The bench drives inputs on the falling edge and compares every output against its behavioural model on the next falling edge, so each result is read only after the edge that produces it. Directed checks then confirm the per-scenario values: decode results, header consumption counts and interrupt counts.

// File: rtl/cactl_pkg.sv
package cactl_pkg;

    typedef enum logic [3:0] {
        CU_IDLE   = 4'd0,
        CU_SUSP   = 4'd1,
        CU_ACTIVE = 4'd2
    } cu_state_t;

    typedef enum logic [3:0] {
        RU_IDLE  = 4'd0,
        RU_SUSP  = 4'd1,
        RU_READY = 4'd4
    } ru_state_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_EXEC = 2'd2
    } walk_state_t;

    // event flags, msb first: done-with-irq, frame rx, cu left, ru left
    typedef struct packed {
        logic cmd_done;
        logic frame_rx;
        logic cu_left;
        logic ru_left;
    } evt_flags_t;

    typedef struct packed {
        logic [3:0] ack;
        logic       spare;
        logic [2:0] cu_op;
        logic       soft_rst;
        logic [2:0] ru_op;
        logic [3:0] low;
    } ctl_word_t;

    typedef struct packed {
        logic       eol;
        logic       susp;
        logic       intr;
        logic [9:0] spare;
        logic [2:0] code;
    } list_hdr_t;

    localparam logic [15:0] STAT_BUSY    = 16'h4000;
    localparam logic [15:0] STAT_DONE_OK = 16'hA000;

    function automatic logic [15:0] pack_status(evt_flags_t f, cu_state_t c, ru_state_t r);
        return {f, c, r, 4'h0};
    endfunction

endpackage

// File: rtl/cactl_pend_cnt.sv
module cactl_pend_cnt #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic nz,
    output logic next_nz
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt, cnt_n;

    always_comb begin
        cnt_n = cnt;
        if (inc && !dec && cnt != MAXV)
            cnt_n = cnt + 1'b1;
        else if (!inc && dec && cnt != '0)
            cnt_n = cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_n;
    end

    assign nz      = (cnt != '0);
    assign next_nz = (cnt_n != '0);
endmodule

// File: rtl/cactl_ctl_decode.sv
module cactl_ctl_decode
    import cactl_pkg::*;
(
    input  ctl_word_t  w,
    input  cu_state_t  cu_i,
    input  ru_state_t  ru_i,
    input  evt_flags_t fl_i,
    output cu_state_t  cu_o,
    output ru_state_t  ru_o,
    output evt_flags_t fl_o,
    output logic       soft_rst
);
    logic unused_ctl;
    assign unused_ctl = ^{w.spare, w.low};

    always_comb begin
        fl_o = evt_flags_t'(fl_i & ~w.ack);
        cu_o = cu_i;
        ru_o = ru_i;
        case (w.cu_op)
            3'd1: cu_o = CU_ACTIVE;
            3'd4: begin
                cu_o = CU_SUSP;
                fl_o.cu_left = 1'b1;
            end
            default: ;
        endcase
        case (w.ru_op)
            3'd1, 3'd2: ru_o = RU_IDLE;
            3'd3, 3'd4: begin
                ru_o = RU_SUSP;
                fl_o.ru_left = 1'b1;
            end
            default: ;
        endcase
        soft_rst = w.soft_rst;
        if (w.soft_rst) begin
            cu_o = CU_IDLE;
            ru_o = RU_SUSP;
            fl_o = '0;
        end
    end
endmodule

// File: rtl/cactl_core.sv
module cactl_core
    import cactl_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ca_pulse,
    input  logic [15:0] ctl_word,
    input  logic        rx_frame_evt,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_hdr,
    input  logic        cmd_link_null,
    output logic        cmd_ready,
    output logic        cmd_stat_we,
    output logic [15:0] cmd_stat,
    output logic [15:0] status_word,
    output logic        irq
);
    walk_state_t st, st_n;
    cu_state_t   cu, cu_n, d_cu;
    ru_state_t   ru, ru_n, d_ru;
    evt_flags_t  fl, fl_n, d_fl;
    list_hdr_t   hdr_q, hdr_n;
    logic        lnull_q, lnull_n;
    logic        send_q, send_n;
    logic        irq_n, we_n;
    logic [15:0] stat_n;
    logic        d_srst, dec, pend_nz, pend_next_nz;

    logic unused_hdr;
    assign unused_hdr = ^{hdr_q.spare, hdr_q.code};

    assign dec = (st == ST_IDLE) && (ca_pulse || pend_nz);

    cactl_pend_cnt #(.W(PEND_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .inc     (ca_pulse),
        .dec     (dec),
        .nz      (pend_nz),
        .next_nz (pend_next_nz)
    );

    cactl_ctl_decode u_dec (
        .w        (ctl_word_t'(ctl_word)),
        .cu_i     (cu),
        .ru_i     (ru),
        .fl_i     (fl),
        .cu_o     (d_cu),
        .ru_o     (d_ru),
        .fl_o     (d_fl),
        .soft_rst (d_srst)
    );

    always_comb begin
        st_n    = st;
        cu_n    = cu;
        ru_n    = ru;
        fl_n    = fl;
        hdr_n   = hdr_q;
        lnull_n = lnull_q;
        send_n  = send_q;
        irq_n   = 1'b0;
        we_n    = 1'b0;
        stat_n  = cmd_stat;
        case (st)
            ST_IDLE: begin
                if (dec) begin
                    cu_n = d_cu;
                    ru_n = d_ru;
                    fl_n = d_fl;
                    if (d_srst) send_n = 1'b0;
                    if (d_cu == CU_ACTIVE) begin
                        st_n = ST_HDR;
                    end else if (!pend_next_nz) begin
                        irq_n  = send_n;
                        send_n = 1'b0;
                    end
                end
            end
            ST_HDR: begin
                if (cmd_valid) begin
                    hdr_n   = list_hdr_t'(cmd_hdr);
                    lnull_n = cmd_link_null;
                    we_n    = 1'b1;
                    stat_n  = STAT_BUSY;
                    st_n    = ST_EXEC;
                end
            end
            ST_EXEC: begin
                we_n        = 1'b1;
                stat_n      = STAT_DONE_OK;
                fl_n.cmd_done = hdr_q.intr;
                if (hdr_q.susp) cu_n = CU_SUSP;
                if (hdr_q.intr) send_n = 1'b1;
                if (cu_n == CU_ACTIVE && !hdr_q.eol && !lnull_q) begin
                    st_n = ST_HDR;
                end else begin
                    st_n = ST_IDLE;
                    if (!pend_next_nz) begin
                        irq_n  = send_n;
                        send_n = 1'b0;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (rx_frame_evt) fl_n.frame_rx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cu          <= CU_IDLE;
            ru          <= RU_SUSP;
            fl          <= '0;
            hdr_q       <= '0;
            lnull_q     <= 1'b0;
            send_q      <= 1'b0;
            irq         <= 1'b0;
            cmd_stat_we <= 1'b0;
            cmd_stat    <= '0;
        end else begin
            st          <= st_n;
            cu          <= cu_n;
            ru          <= ru_n;
            fl          <= fl_n;
            hdr_q       <= hdr_n;
            lnull_q     <= lnull_n;
            send_q      <= send_n;
            irq         <= irq_n;
            cmd_stat_we <= we_n;
            cmd_stat    <= stat_n;
        end
    end

    assign cmd_ready   = (st == ST_HDR);
    assign status_word = pack_status(fl, cu, ru);
endmodule

// File: rtl/cactl_core_chk.sv
module cactl_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [15:0] cmd_hdr,
    input logic        cmd_ready,
    input logic        cmd_stat_we,
    input logic [15:0] cmd_stat,
    input logic [15:0] status_word,
    input logic        irq
);
    assert_status_codes_R2: assert property (@(posedge clk) disable iff (rst)
        (status_word[11:8] inside {4'd0, 4'd1, 4'd2}) &&
        (status_word[7:4] inside {4'd0, 4'd1, 4'd4}) && (status_word[3:0] == 4'd0));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (cmd_stat_we && cmd_stat == 16'h4000));

    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_stat_we && cmd_stat == 16'h4000) |=> (cmd_stat_we && cmd_stat == 16'hA000));

    assert_done_flag_follows_hdr_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && cmd_ready, 2) |-> (status_word[15] == $past(cmd_hdr[13], 2)));

    assert_suspend_stops_walk_R10: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && cmd_ready && cmd_hdr[14], 2) |-> (status_word[11:8] == 4'd1 && !cmd_ready));

    assert_irq_single_R11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> !cmd_ready);
endmodule

bind cactl_core cactl_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_hdr     (cmd_hdr),
    .cmd_ready   (cmd_ready),
    .cmd_stat_we (cmd_stat_we),
    .cmd_stat    (cmd_stat),
    .status_word (status_word),
    .irq         (irq)
);

// File: tb/cactl_core_test.sv
module cactl_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ca_pulse = 1'b0;
    logic [15:0] ctl_word = '0;
    logic        rx_frame_evt = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_hdr = '0;
    logic        cmd_link_null = 1'b0;
    logic        cmd_ready;
    logic        cmd_stat_we;
    logic [15:0] cmd_stat;
    logic [15:0] status_word;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    cactl_core uut (
        .clk           (clk),
        .rst           (rst),
        .ca_pulse      (ca_pulse),
        .ctl_word      (ctl_word),
        .rx_frame_evt  (rx_frame_evt),
        .cmd_valid     (cmd_valid),
        .cmd_hdr       (cmd_hdr),
        .cmd_link_null (cmd_link_null),
        .cmd_ready     (cmd_ready),
        .cmd_stat_we   (cmd_stat_we),
        .cmd_stat      (cmd_stat),
        .status_word   (status_word),
        .irq           (irq)
    );

    int ntests = 0;
    int nfail  = 0;
    int cycles = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st, m_cu, m_ru, m_fl, m_cnt, m_send, m_irq, m_we, m_stat, m_hdr, m_nul, m_w;
    bit m_init = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cu = 0; m_ru = 1; m_fl = 0; m_cnt = 0; m_send = 0;
            m_irq = 0; m_we = 0; m_stat = 0; m_hdr = 0; m_nul = 0; m_init = 1;
        end else begin
            m_irq = 0;
            m_we  = 0;
            if (m_st == 0 && (ca_pulse || m_cnt > 0)) begin
                m_w = int'(ctl_word);
                m_fl = m_fl & ~((m_w >> 12) & 15);
                case ((m_w >> 8) & 7)
                    1: m_cu = 2;
                    4: begin m_cu = 1; m_fl = m_fl | 2; end
                    default: ;
                endcase
                case ((m_w >> 4) & 7)
                    1, 2: m_ru = 0;
                    3, 4: begin m_ru = 1; m_fl = m_fl | 1; end
                    default: ;
                endcase
                if ((m_w & 'h80) != 0) begin
                    m_cu = 0; m_ru = 1; m_fl = 0; m_send = 0;
                end
                if (!ca_pulse) m_cnt--;
                if (m_cu == 2) m_st = 1;
                else if (m_cnt == 0) begin m_irq = m_send; m_send = 0; end
            end else begin
                if (ca_pulse && m_cnt < 15) m_cnt++;
                if (m_st == 1) begin
                    if (cmd_valid) begin
                        m_hdr = int'(cmd_hdr); m_nul = int'(cmd_link_null);
                        m_we = 1; m_stat = 'h4000; m_st = 2;
                    end
                end else if (m_st == 2) begin
                    m_we = 1; m_stat = 'hA000;
                    m_fl = (m_fl & 7) | (((m_hdr >> 13) & 1) << 3);
                    if ((m_hdr & 'h4000) != 0) m_cu = 1;
                    if ((m_hdr & 'h2000) != 0) m_send = 1;
                    if (m_cu == 2 && (m_hdr & 'h8000) == 0 && m_nul == 0) m_st = 1;
                    else begin
                        m_st = 0;
                        if (m_cnt == 0) begin m_irq = m_send; m_send = 0; end
                    end
                end
            end
            if (rx_frame_evt) m_fl = m_fl | 4;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (m_init && !finished) begin
            int exp_sw;
            exp_sw = (m_fl << 12) | (m_cu << 8) | (m_ru << 4);
            chk(status_word == exp_sw[15:0], "R2 status_word vs model", status_word, exp_sw);
            chk(irq == m_irq[0], "R11 irq vs model", irq, m_irq);
            chk(cmd_ready == (m_st == 1), "R8 cmd_ready vs model", cmd_ready, (m_st == 1));
            chk(cmd_stat_we == m_we[0] && (!m_we[0] || cmd_stat == m_stat[15:0]),
                "R8 status strobe vs model", {cmd_stat_we, cmd_stat}, {m_we[0], m_stat[15:0]});
        end
    end

    // ---------------- header feeder ----------------
    logic [16:0] hq[$];
    int consumed = 0;
    bit fire_pend = 0;

    always @(negedge clk) begin
        if (fire_pend && hq.size() > 0) begin
            hq.delete(0);
            consumed++;
        end
        if (hq.size() > 0) begin
            cmd_valid = 1'b1;
            {cmd_link_null, cmd_hdr} = hq[0];
        end else begin
            cmd_valid = 1'b0;
        end
        fire_pend = cmd_valid && cmd_ready;
    end

    // ---------------- event counters ----------------
    int irq_cnt = 0, busy_cnt = 0, done_cnt = 0, ready_seen = 0;
    always @(negedge clk) begin
        if (m_init) begin
            if (irq) irq_cnt++;
            if (cmd_stat_we && cmd_stat == 16'h4000) busy_cnt++;
            if (cmd_stat_we && cmd_stat == 16'hA000) done_cnt++;
            if (cmd_ready) ready_seen++;
        end
    end

    task automatic clear_counts();
        irq_cnt = 0; busy_cnt = 0; done_cnt = 0; ready_seen = 0; consumed = 0;
    endtask

    task automatic do_ca(input logic [15:0] w);
        @(negedge clk);
        ca_pulse = 1'b1;
        ctl_word = w;
        @(negedge clk);
        ca_pulse = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            ntests++;
            nfail++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(status_word == 16'h0010, "R1 reset status", status_word, 16'h0010);
        chk(!cmd_ready && !cmd_stat_we && !irq, "R1 reset outputs",
            {cmd_ready, cmd_stat_we, irq}, 3'b000);

        // R13 frame event sets bit 14
        @(negedge clk); rx_frame_evt = 1'b1;
        @(negedge clk); rx_frame_evt = 1'b0;
        chk(status_word == 16'h4010, "R13 frame flag", status_word, 16'h4010);

        // R13 event wins over same-cycle acknowledge
        @(negedge clk); ca_pulse = 1'b1; ctl_word = 16'h4000; rx_frame_evt = 1'b1;
        @(negedge clk); ca_pulse = 1'b0; rx_frame_evt = 1'b0;
        chk(status_word == 16'h4010, "R13 event beats ack", status_word, 16'h4010);

        // R3 ack clears, R5 ru start -> idle, R7 visible one edge after pulse
        do_ca(16'h4010);
        chk(status_word == 16'h0000, "R3 R5 R7 ack and ru idle", status_word, 16'h0000);

        // R4 cu suspend sets bit13, R5 ru suspend sets bit12
        do_ca(16'h0430);
        chk(status_word == 16'h3110, "R4 R5 suspend opcodes", status_word, 16'h3110);

        // R4 unknown cu opcode ignored, R3 ack of both flags
        do_ca(16'h3700);
        chk(status_word == 16'h0110, "R4 unknown opcode, R3 ack", status_word, 16'h0110);

        // R6 soft reset overrides ru abort
        do_ca(16'h00C0);
        chk(status_word == 16'h0010, "R6 soft reset", status_word, 16'h0010);
        chk(ready_seen == 0, "R10 no walk while cu idle", ready_seen, 0);

        // walk: intr, plain, end-of-list
        clear_counts();
        hq.push_back({1'b0, 16'h2004});
        hq.push_back({1'b0, 16'h0000});
        hq.push_back({1'b0, 16'h8000});
        do_ca(16'h0100);
        chk(cmd_ready == 1'b1, "R8 ready after cu start", cmd_ready, 1'b1);
        repeat (20) @(negedge clk);
        chk(consumed == 3, "R10 end-of-list consumption", consumed, 3);
        chk(busy_cnt == 3 && done_cnt == 3, "R8 busy/done strobes", {busy_cnt[15:0], done_cnt[15:0]}, {16'd3, 16'd3});
        chk(irq_cnt == 1, "R11 one irq after walk", irq_cnt, 1);
        chk(status_word == 16'h0210, "R9 R10 done flag cleared, cu active", status_word, 16'h0210);

        // R12 pulses counted during a walk, each re-decodes
        clear_counts();
        hq.push_back({1'b0, 16'h0000});
        hq.push_back({1'b0, 16'h8000});
        hq.push_back({1'b0, 16'hA000});
        hq.push_back({1'b0, 16'h4000});
        do_ca(16'h0000);
        ca_pulse = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ca_pulse = 1'b0;
        repeat (30) @(negedge clk);
        chk(consumed == 4, "R12 three walks from counted pulses", consumed, 4);
        chk(irq_cnt == 1, "R11 R12 irq only at final end", irq_cnt, 1);
        chk(status_word == 16'h0110, "R10 suspend-after", status_word, 16'h0110);

        // R10 decode with cu suspended starts no walk
        clear_counts();
        do_ca(16'h0000);
        repeat (5) @(negedge clk);
        chk(ready_seen == 0, "R10 suspended cu no walk", ready_seen, 0);

        // R10 null link stops walk, cu stays active
        clear_counts();
        hq.push_back({1'b1, 16'h0000});
        hq.push_back({1'b0, 16'h0000});
        do_ca(16'h0100);
        repeat (10) @(negedge clk);
        chk(consumed == 1, "R10 null link stop", consumed, 1);
        chk(status_word == 16'h0210, "R10 cu active after null link", status_word, 16'h0210);
        chk(irq_cnt == 0, "R11 no irq without intr", irq_cnt, 0);
        hq.delete();

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule